// File: doc/BRIEF.md
# Fault Status and Escalation Unit

This block gathers fault events from a small processor core into sticky status flags. Each event is a one-cycle pulse tagged with a fault group (memory protection, bus, or usage), a code, a precise/imprecise attribute and an address. For the memory-protection and bus groups the code is the phase in which the fault occurred: instruction fetch, data access, exception stacking, exception unstacking, or lazy floating-point save. For the usage group the code names the kind of usage error.

Every accepted event sets its flag. The core then either takes the fault as its own exception or turns it into a hard fault. A fault is turned into a hard fault when its group is disabled or when the priority logic reports that it cannot be made active. In that case a forced-escalation flag is set in the hard-fault register. Data-access faults in the memory-protection group, and precise data errors in the bus group, also latch the faulting address together with a valid flag.

Software reads the flags over a small word-select bus. It clears any flag by writing 1 to it. The exception request outputs are one-cycle pulses for a separate priority arbiter.

Top module: `fault_status_unit`

## Requirements
- R1: After reset, all four readable words (status at select 0, hard-fault at select 1, memory-protection address at select 2, bus-fault address at select 3) read 0, and all request outputs are low.
- R2: A memory-protection event (group 0) sets a status-word bit one cycle later, chosen by its code: fetch (code 0) sets bit 0, data access (code 1) sets bit 1, unstacking (code 2) sets bit 3, stacking (code 3) sets bit 4, and lazy save (code 4) sets bit 5.
- R3: A bus event (group 1) sets a status-word bit chosen by its code: fetch sets bit 8, precise data access sets bit 9, imprecise data access sets bit 10, unstacking sets bit 11, stacking sets bit 12, and lazy save sets bit 13.
- R4: A usage event (group 2) with codes 0 to 6 sets status-word bits 16, 17, 18, 19, 20, 24 and 25 respectively. These are undefined instruction, invalid state, invalid PC, no coprocessor, stack overflow, unaligned access and divide by zero.
- R5: Flags are sticky. Writing 0 to a flag, or letting time pass, leaves it set.
- R6: Writing 1 to a bit of the status word (select 0) or of the hard-fault word (select 1) clears that bit. If an event sets the bit in the same cycle as the clear, the bit stays set.
- R7: A memory data-access event sets status bit 7 and loads the address word at select 2. A bus precise data event sets bit 15 and loads select 3. The address is loaded only when the valid bit is clear, or is being cleared in that same cycle. Otherwise the first address is kept.
- R8: An imprecise bus data error never sets bit 15 and never changes the bus-fault address.
- R9: An event whose group enable bit is 1 (enable bit 0 for memory, 1 for bus, 2 for usage), while priority blocking is low, pulses the matching request for exactly one cycle, starting one cycle after the event. No hard request is raised.
- R10: An event whose group is disabled, or that arrives while priority blocking is high, raises the hard request instead, one cycle later. It sets hard-word bit 30 and raises no group request. Its group flag is still recorded.
- R11: A vector-table read error sets hard-word bit 1, and a debug event sets hard-word bit 31. Each raises a one-cycle hard request.
- R12: Codes 5 to 7 in the memory and bus groups, code 7 in the usage group, and group 3 are ignored. They set no flag and raise no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | One-cycle fault event strobe |
| evt_grp | input | 2 | Fault group: 0 memory protection, 1 bus, 2 usage, 3 none |
| evt_code | input | 3 | Phase code (memory/bus) or usage error kind |
| evt_precise | input | 1 | Bus data error is precise |
| evt_addr | input | ADDR_W | Faulting address |
| vtbl_err | input | 1 | Vector table read error strobe |
| dbg_evt | input | 1 | Debug event strobe |
| grp_en | input | 3 | Per-group enables (bit 0 memory, 1 bus, 2 usage) |
| prio_blocked | input | 1 | Fault cannot be activated at its priority |
| bus_sel | input | 2 | Register word select |
| bus_wr | input | 1 | Write strobe (write-one-to-clear) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected word |
| req_mem | output | 1 | Memory-protection exception request |
| req_bus | output | 1 | Bus-fault exception request |
| req_usage | output | 1 | Usage-fault exception request |
| req_hard | output | 1 | Hard-fault exception request |

## Verification
The main test loops over every phase code of the memory and bus groups, every usage code, and the unused codes. Each of these is applied once with all groups enabled, which tells apart the bit each code sets and the group request it raises. The same events are then repeated with one group disabled, and with priority blocking raised. These repeats separate a fault that is taken normally from one that is forced to a hard fault, and show that the group flag is still recorded. Directed sequences then cover the following cases:
- events that collide with a clear of the same bit
- several data-access faults in a row, which separate the first address from later ones
- an imprecise bus error after a precise one, which shows that the imprecise error leaves the latched address alone

// File: rtl/fsu_pkg.sv
`timescale 1ns/1ps
package fsu_pkg;
   localparam int unsigned DATA_W   = 32;
   localparam int unsigned NGRP     = 3;
   localparam int unsigned GRP_W    = 8;
   localparam int unsigned USG_W    = 16;

   // group selectors
   localparam logic [1:0] GRP_MEM  = 2'd0;
   localparam logic [1:0] GRP_BUS  = 2'd1;
   localparam logic [1:0] GRP_USG  = 2'd2;

   // phase codes shared by the memory-protection and bus groups
   localparam logic [2:0] PH_FETCH   = 3'd0;
   localparam logic [2:0] PH_DATA    = 3'd1;
   localparam logic [2:0] PH_UNSTACK = 3'd2;
   localparam logic [2:0] PH_STACK   = 3'd3;
   localparam logic [2:0] PH_LAZY    = 3'd4;

   // register word selects
   localparam logic [1:0] SEL_STATUS   = 2'd0;
   localparam logic [1:0] SEL_HARD     = 2'd1;
   localparam logic [1:0] SEL_MEM_ADDR = 2'd2;
   localparam logic [1:0] SEL_BUS_ADDR = 2'd3;

   // implemented bits of each flag word
   localparam logic [GRP_W-1:0]  MEM_MASK  = 8'hBB;
   localparam logic [GRP_W-1:0]  BUS_MASK  = 8'hBF;
   localparam logic [USG_W-1:0]  USG_MASK  = 16'h031F;
   localparam logic [DATA_W-1:0] HARD_MASK = 32'hC000_0002;

   localparam int unsigned VALID_BIT  = 7;
   localparam int unsigned HARD_DBG   = 31;
   localparam int unsigned HARD_FORCE = 30;
   localparam int unsigned HARD_VTBL  = 1;
endpackage

// File: rtl/fsu_event_decode.sv
`timescale 1ns/1ps
module fsu_event_decode
   import fsu_pkg::*;
(
   input  logic                 evt_valid,
   input  logic [1:0]           evt_grp,
   input  logic [2:0]           evt_code,
   input  logic                 evt_precise,
   output logic [GRP_W-1:0]     mem_set,
   output logic [GRP_W-1:0]     bus_set,
   output logic [USG_W-1:0]     usg_set,
   output logic [NGRP-1:0]      grp_hit,
   output logic                 mem_cap,
   output logic                 bus_cap
);
   // phase code to flag vector for the memory and bus groups
   function automatic logic [GRP_W-1:0] phase_vec(input logic [2:0] code,
                                                  input logic       is_bus,
                                                  input logic       precise);
      logic [GRP_W-1:0] v;
      v = '0;
      case (code)
         PH_FETCH:   v[0] = 1'b1;
         PH_DATA: begin
            if (!is_bus || precise) begin
               v[1]         = 1'b1;
               v[VALID_BIT] = 1'b1;
            end else begin
               v[2] = 1'b1;
            end
         end
         PH_UNSTACK: v[3] = 1'b1;
         PH_STACK:   v[4] = 1'b1;
         PH_LAZY:    v[5] = 1'b1;
         default:    v = '0;
      endcase
      return v;
   endfunction

   function automatic logic [USG_W-1:0] usage_vec(input logic [2:0] code);
      logic [USG_W-1:0] v;
      v = '0;
      case (code)
         3'd0, 3'd1, 3'd2, 3'd3, 3'd4: v[code] = 1'b1;
         3'd5:    v[8] = 1'b1;
         3'd6:    v[9] = 1'b1;
         default: v = '0;
      endcase
      return v;
   endfunction

   logic [GRP_W-1:0] mem_v, bus_v;
   logic [USG_W-1:0] usg_v;

   always_comb begin
      mem_v = phase_vec(evt_code, 1'b0, evt_precise);
      bus_v = phase_vec(evt_code, 1'b1, evt_precise);
      usg_v = usage_vec(evt_code);
      mem_set = '0;
      bus_set = '0;
      usg_set = '0;
      if (evt_valid) begin
         case (evt_grp)
            GRP_MEM: mem_set = mem_v;
            GRP_BUS: bus_set = bus_v;
            GRP_USG: usg_set = usg_v;
            default: ;
         endcase
      end
      grp_hit = {|usg_set, |bus_set, |mem_set};
      mem_cap = mem_set[VALID_BIT];
      bus_cap = bus_set[VALID_BIT];
   end
endmodule

// File: rtl/fsu_flag_bank.sv
`timescale 1ns/1ps
module fsu_flag_bank #(
   parameter int unsigned     WIDTH = 8,
   parameter logic [WIDTH-1:0] MASK = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] set_i,
   input  logic [WIDTH-1:0] clr_i,
   output logic [WIDTH-1:0] flag_o
);
   if (WIDTH < 1) begin : g_bad_width
      $error("fsu_flag_bank: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] flag_d;

   // set has priority over a same-cycle write-one clear
   always_comb flag_d = ((flag_o & ~clr_i) | set_i) & MASK;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_o <= '0;
      else        flag_o <= flag_d;
   end

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      ((set_i & MASK) != '0) |=> ((flag_o & $past(set_i & MASK)) == $past(set_i & MASK))); // R6
   AST_UNCLEARED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((($past(flag_o) & ~$past(clr_i)) & ~flag_o) == '0)); // R5
endmodule

// File: rtl/fsu_addr_capture.sv
`timescale 1ns/1ps
module fsu_addr_capture #(
   parameter int unsigned ADDR_W     = 32,
   parameter bit          KEEP_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_i,
   input  logic              valid_q_i,
   input  logic              valid_clr_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic [ADDR_W-1:0] addr_o
);
   logic open;

   if (KEEP_FIRST) begin : g_keep_first
      assign open = !valid_q_i || valid_clr_i;
      AST_ADDR_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
         (valid_q_i && !valid_clr_i) |=> $stable(addr_o)); // R7
   end else begin : g_keep_last
      assign open = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             addr_o <= '0;
      else if (cap_i && open) addr_o <= addr_i;
   end

   AST_ADDR_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_i && !valid_q_i) |=> (addr_o == $past(addr_i))); // R7
endmodule

// File: rtl/fsu_escalate.sv
`timescale 1ns/1ps
module fsu_escalate #(
   parameter int unsigned NG = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NG-1:0] grp_hit,
   input  logic [NG-1:0] grp_en,
   input  logic          prio_blocked,
   input  logic          vtbl_err,
   input  logic          dbg_evt,
   output logic          forced_o,
   output logic [NG-1:0] req_grp_o,
   output logic          req_hard_o
);
   logic [NG-1:0] take, esc;

   always_comb begin
      take     = grp_hit & grp_en & {NG{!prio_blocked}};
      esc      = grp_hit & ~take;
      forced_o = |esc;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_grp_o  <= '0;
         req_hard_o <= 1'b0;
      end else begin
         req_grp_o  <= take;
         req_hard_o <= forced_o | vtbl_err | dbg_evt;
      end
   end

   AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grp_hit)); // R9
   AST_TAKEN_OWN: assert property (@(posedge clk) disable iff (!rst_n)
      ((|(grp_hit & grp_en)) && !prio_blocked) |=> (req_grp_o == $past(grp_hit))); // R9
   AST_ESCALATED: assert property (@(posedge clk) disable iff (!rst_n)
      ((|grp_hit) && (prio_blocked || !(|(grp_hit & grp_en)))) |=> (req_hard_o && (req_grp_o == '0))); // R10
   AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      ((req_grp_o != '0) && (grp_hit == '0)) |=> (req_grp_o == '0)); // R9
endmodule

// File: rtl/fault_status_unit.sv
`timescale 1ns/1ps
module fault_status_unit
   import fsu_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter bit          KEEP_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              evt_valid,
   input  logic [1:0]        evt_grp,
   input  logic [2:0]        evt_code,
   input  logic              evt_precise,
   input  logic [ADDR_W-1:0] evt_addr,
   input  logic              vtbl_err,
   input  logic              dbg_evt,
   input  logic [2:0]        grp_en,
   input  logic              prio_blocked,
   input  logic [1:0]        bus_sel,
   input  logic              bus_wr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              req_mem,
   output logic              req_bus,
   output logic              req_usage,
   output logic              req_hard
);
   localparam int unsigned STAT_BUS_LO = GRP_W;
   localparam int unsigned STAT_USG_LO = 2 * GRP_W;

   if (ADDR_W < 1 || ADDR_W > DATA_W) begin : g_bad_addr
      $error("fault_status_unit: ADDR_W must lie in 1..32");
   end
   if (STAT_USG_LO + USG_W != DATA_W) begin : g_bad_pack
      $error("fault_status_unit: flag groups do not fill the status word");
   end

   logic [GRP_W-1:0]  mem_set, bus_set, mem_flags, bus_flags, mem_clr, bus_clr;
   logic [USG_W-1:0]  usg_set, usg_flags, usg_clr;
   logic [DATA_W-1:0] hard_set, hard_flags, hard_clr;
   logic [NGRP-1:0]   grp_hit, req_grp;
   logic              mem_cap, bus_cap, forced;
   logic [ADDR_W-1:0] mem_addr, bus_addr;
   logic              wr_status, wr_hard;

   fsu_event_decode u_decode (
      .evt_valid   (evt_valid),
      .evt_grp     (evt_grp),
      .evt_code    (evt_code),
      .evt_precise (evt_precise),
      .mem_set     (mem_set),
      .bus_set     (bus_set),
      .usg_set     (usg_set),
      .grp_hit     (grp_hit),
      .mem_cap     (mem_cap),
      .bus_cap     (bus_cap)
   );

   fsu_escalate #(.NG(NGRP)) u_escalate (
      .clk          (clk),
      .rst_n        (rst_n),
      .grp_hit      (grp_hit),
      .grp_en       (grp_en),
      .prio_blocked (prio_blocked),
      .vtbl_err     (vtbl_err),
      .dbg_evt      (dbg_evt),
      .forced_o     (forced),
      .req_grp_o    (req_grp),
      .req_hard_o   (req_hard)
   );

   // write-one-to-clear strobes
   always_comb begin
      wr_status = bus_wr && (bus_sel == SEL_STATUS);
      wr_hard   = bus_wr && (bus_sel == SEL_HARD);
      mem_clr   = wr_status ? bus_wdata[STAT_BUS_LO-1:0]           : '0;
      bus_clr   = wr_status ? bus_wdata[STAT_USG_LO-1:STAT_BUS_LO] : '0;
      usg_clr   = wr_status ? bus_wdata[DATA_W-1:STAT_USG_LO]      : '0;
      hard_clr  = wr_hard   ? bus_wdata                            : '0;
      hard_set  = '0;
      hard_set[HARD_DBG]   = dbg_evt;
      hard_set[HARD_FORCE] = forced;
      hard_set[HARD_VTBL]  = vtbl_err;
   end

   fsu_flag_bank #(.WIDTH(GRP_W), .MASK(MEM_MASK)) u_mem_flags (
      .clk(clk), .rst_n(rst_n), .set_i(mem_set), .clr_i(mem_clr), .flag_o(mem_flags));
   fsu_flag_bank #(.WIDTH(GRP_W), .MASK(BUS_MASK)) u_bus_flags (
      .clk(clk), .rst_n(rst_n), .set_i(bus_set), .clr_i(bus_clr), .flag_o(bus_flags));
   fsu_flag_bank #(.WIDTH(USG_W), .MASK(USG_MASK)) u_usg_flags (
      .clk(clk), .rst_n(rst_n), .set_i(usg_set), .clr_i(usg_clr), .flag_o(usg_flags));
   fsu_flag_bank #(.WIDTH(DATA_W), .MASK(HARD_MASK)) u_hard_flags (
      .clk(clk), .rst_n(rst_n), .set_i(hard_set), .clr_i(hard_clr), .flag_o(hard_flags));

   fsu_addr_capture #(.ADDR_W(ADDR_W), .KEEP_FIRST(KEEP_FIRST)) u_mem_addr (
      .clk         (clk),
      .rst_n       (rst_n),
      .cap_i       (mem_cap),
      .valid_q_i   (mem_flags[VALID_BIT]),
      .valid_clr_i (mem_clr[VALID_BIT]),
      .addr_i      (evt_addr),
      .addr_o      (mem_addr)
   );

   fsu_addr_capture #(.ADDR_W(ADDR_W), .KEEP_FIRST(KEEP_FIRST)) u_bus_addr (
      .clk         (clk),
      .rst_n       (rst_n),
      .cap_i       (bus_cap),
      .valid_q_i   (bus_flags[VALID_BIT]),
      .valid_clr_i (bus_clr[VALID_BIT]),
      .addr_i      (evt_addr),
      .addr_o      (bus_addr)
   );

   always_comb begin
      bus_rdata = '0;
      case (bus_sel)
         SEL_STATUS:   bus_rdata = {usg_flags, bus_flags, mem_flags};
         SEL_HARD:     bus_rdata = hard_flags;
         SEL_MEM_ADDR: bus_rdata[ADDR_W-1:0] = mem_addr;
         SEL_BUS_ADDR: bus_rdata[ADDR_W-1:0] = bus_addr;
         default:      bus_rdata = '0;
      endcase
   end

   assign req_mem   = req_grp[0];
   assign req_bus   = req_grp[1];
   assign req_usage = req_grp[2];

   AST_IMPRECISE_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && evt_grp == GRP_BUS && evt_code == PH_DATA && !evt_precise)
         |=> $stable(bus_addr)); // R8
   AST_VTBL_HARD: assert property (@(posedge clk) disable iff (!rst_n)
      (vtbl_err || dbg_evt) |=> req_hard); // R11
endmodule

// File: tb/fault_status_unit_tb.sv
`timescale 1ns/1ps
module fault_status_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        evt_valid, evt_precise, vtbl_err, dbg_evt, prio_blocked, bus_wr;
   logic [1:0]  evt_grp, bus_sel;
   logic [2:0]  evt_code, grp_en;
   logic [31:0] evt_addr, bus_wdata, bus_rdata;
   logic        req_mem, req_bus, req_usage, req_hard;

   int n_chk = 0;
   int n_err = 0;

   always #2 clk = ~clk;

   fault_status_unit u_dut (
      .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_grp(evt_grp),
      .evt_code(evt_code), .evt_precise(evt_precise), .evt_addr(evt_addr),
      .vtbl_err(vtbl_err), .dbg_evt(dbg_evt), .grp_en(grp_en),
      .prio_blocked(prio_blocked), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .req_mem(req_mem),
      .req_bus(req_bus), .req_usage(req_usage), .req_hard(req_hard));

   // {grp[2], code[3], precise, en[3], blocked, status[32], req{hard,usg,bus,mem}, hard[32]}
   localparam int NV = 24;
   localparam logic [77:0] VEC [NV] = '{
      {2'd0, 3'd0, 1'b1, 3'b111, 1'b0, 32'h0000_0001, 4'b0001, 32'h0},
      {2'd0, 3'd1, 1'b1, 3'b111, 1'b0, 32'h0000_0082, 4'b0001, 32'h0},
      {2'd0, 3'd2, 1'b1, 3'b111, 1'b0, 32'h0000_0008, 4'b0001, 32'h0},
      {2'd0, 3'd3, 1'b1, 3'b111, 1'b0, 32'h0000_0010, 4'b0001, 32'h0},
      {2'd0, 3'd4, 1'b1, 3'b111, 1'b0, 32'h0000_0020, 4'b0001, 32'h0},
      {2'd1, 3'd0, 1'b1, 3'b111, 1'b0, 32'h0000_0100, 4'b0010, 32'h0},
      {2'd1, 3'd1, 1'b1, 3'b111, 1'b0, 32'h0000_8200, 4'b0010, 32'h0},
      {2'd1, 3'd1, 1'b0, 3'b111, 1'b0, 32'h0000_0400, 4'b0010, 32'h0},
      {2'd1, 3'd2, 1'b1, 3'b111, 1'b0, 32'h0000_0800, 4'b0010, 32'h0},
      {2'd1, 3'd3, 1'b1, 3'b111, 1'b0, 32'h0000_1000, 4'b0010, 32'h0},
      {2'd1, 3'd4, 1'b1, 3'b111, 1'b0, 32'h0000_2000, 4'b0010, 32'h0},
      {2'd2, 3'd0, 1'b0, 3'b111, 1'b0, 32'h0001_0000, 4'b0100, 32'h0},
      {2'd2, 3'd1, 1'b0, 3'b111, 1'b0, 32'h0002_0000, 4'b0100, 32'h0},
      {2'd2, 3'd2, 1'b0, 3'b111, 1'b0, 32'h0004_0000, 4'b0100, 32'h0},
      {2'd2, 3'd3, 1'b0, 3'b111, 1'b0, 32'h0008_0000, 4'b0100, 32'h0},
      {2'd2, 3'd4, 1'b0, 3'b111, 1'b0, 32'h0010_0000, 4'b0100, 32'h0},
      {2'd2, 3'd5, 1'b0, 3'b111, 1'b0, 32'h0100_0000, 4'b0100, 32'h0},
      {2'd2, 3'd6, 1'b0, 3'b111, 1'b0, 32'h0200_0000, 4'b0100, 32'h0},
      {2'd0, 3'd0, 1'b1, 3'b110, 1'b0, 32'h0000_0001, 4'b1000, 32'h4000_0000},
      {2'd1, 3'd0, 1'b1, 3'b111, 1'b1, 32'h0000_0100, 4'b1000, 32'h4000_0000},
      {2'd2, 3'd0, 1'b0, 3'b011, 1'b0, 32'h0001_0000, 4'b1000, 32'h4000_0000},
      {2'd0, 3'd5, 1'b1, 3'b111, 1'b0, 32'h0000_0000, 4'b0000, 32'h0},
      {2'd2, 3'd7, 1'b0, 3'b111, 1'b0, 32'h0000_0000, 4'b0000, 32'h0},
      {2'd3, 3'd0, 1'b1, 3'b111, 1'b0, 32'h0000_0000, 4'b0000, 32'h0}
   };

   function automatic string tag_of(input logic [1:0] g, input logic [2:0] c,
                                    input logic p, input logic [3:0] r);
      if (r[3])                        return "R10";
      if (r == 4'b0000)                return "R12";
      if (g == 2'd1 && c == 3'd1 && !p) return "R8";
      if (g == 2'd0)                   return "R2";
      if (g == 2'd1)                   return "R3";
      return "R4";
   endfunction

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic check_rd(input string tag, input logic [1:0] sel, input logic [31:0] exp);
      bus_sel = sel;
      #0.2;
      check(tag, bus_rdata, exp);
   endtask

   task automatic idle();
      evt_valid = 1'b0; vtbl_err = 1'b0; dbg_evt = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic wr(input logic [1:0] sel, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_sel = sel; bus_wdata = d;
      @(negedge clk);
      idle();
   endtask

   task automatic clear_all();
      wr(2'd0, 32'hFFFF_FFFF);
      wr(2'd1, 32'hFFFF_FFFF);
   endtask

   // one event, optionally colliding with a write; returns just after the capture edge
   task automatic fire(input logic [1:0] g, input logic [2:0] c, input logic p,
                       input logic [31:0] a, input logic do_wr,
                       input logic [1:0] sel, input logic [31:0] d);
      @(negedge clk);
      evt_valid = 1'b1; evt_grp = g; evt_code = c; evt_precise = p; evt_addr = a;
      bus_wr = do_wr; bus_sel = sel; bus_wdata = d;
      @(negedge clk);
      idle();
   endtask

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog got timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      idle();
      evt_grp = 2'd0; evt_code = 3'd0; evt_precise = 1'b0; evt_addr = '0;
      grp_en = 3'b111; prio_blocked = 1'b0; bus_sel = 2'd0; bus_wdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check_rd("R1 status", 2'd0, 32'h0);
      check_rd("R1 hard", 2'd1, 32'h0);
      check_rd("R1 mem addr", 2'd2, 32'h0);
      check_rd("R1 bus addr", 2'd3, 32'h0);
      check("R1 requests", {28'h0, req_hard, req_usage, req_bus, req_mem}, 32'h0);

      // table walk: R2 R3 R4 R8 R9 R10 R12
      for (int i = 0; i < NV; i++) begin
         logic [77:0] v;
         string       t;
         v = VEC[i];
         t = tag_of(v[77:76], v[75:73], v[72], v[35:32]);
         clear_all();
         grp_en = v[71:69];
         prio_blocked = v[68];
         fire(v[77:76], v[75:73], v[72], 32'h4000_0000 + 32'(i), 1'b0, 2'd0, 32'h0);
         check({t, " requests"}, {28'h0, req_hard, req_usage, req_bus, req_mem}, {28'h0, v[35:32]});
         check_rd({t, " status"}, 2'd0, v[67:36]);
         check_rd({t, " hard"}, 2'd1, v[31:0]);
         grp_en = 3'b111;
         prio_blocked = 1'b0;
      end

      // R5 sticky, zero write has no effect
      clear_all();
      fire(2'd0, 3'd0, 1'b1, 32'h0, 1'b0, 2'd0, 32'h0);
      wr(2'd0, 32'h0);
      check_rd("R5 zero write", 2'd0, 32'h1);
      repeat (3) @(negedge clk);
      check_rd("R5 held", 2'd0, 32'h1);

      // R6 write-one clear and collisions
      wr(2'd0, 32'h1);
      check_rd("R6 cleared", 2'd0, 32'h0);
      fire(2'd0, 3'd0, 1'b1, 32'h0, 1'b1, 2'd0, 32'h1);
      check_rd("R6 event wins", 2'd0, 32'h1);
      @(negedge clk);
      vtbl_err = 1'b1; bus_wr = 1'b1; bus_sel = 2'd1; bus_wdata = 32'h2;
      @(negedge clk);
      idle();
      check_rd("R6 hard event wins", 2'd1, 32'h2);

      // R7 address capture keeps first
      clear_all();
      fire(2'd0, 3'd1, 1'b1, 32'hA000_0010, 1'b0, 2'd0, 32'h0);
      check_rd("R7 first addr", 2'd2, 32'hA000_0010);
      check_rd("R7 valid set", 2'd0, 32'h82);
      fire(2'd0, 3'd1, 1'b1, 32'hB000_0020, 1'b0, 2'd0, 32'h0);
      check_rd("R7 second kept", 2'd2, 32'hA000_0010);
      wr(2'd0, 32'h80);
      check_rd("R7 valid cleared", 2'd0, 32'h02);
      fire(2'd0, 3'd1, 1'b1, 32'hC000_0030, 1'b0, 2'd0, 32'h0);
      check_rd("R7 reload", 2'd2, 32'hC000_0030);
      fire(2'd0, 3'd1, 1'b1, 32'hD000_0040, 1'b1, 2'd0, 32'h80);
      check_rd("R7 clear collision addr", 2'd2, 32'hD000_0040);
      check_rd("R7 clear collision valid", 2'd0, 32'h82);
      clear_all();
      fire(2'd1, 3'd1, 1'b1, 32'hE000_0050, 1'b0, 2'd0, 32'h0);
      check_rd("R7 bus addr", 2'd3, 32'hE000_0050);

      // R8 imprecise leaves bus address and valid alone
      wr(2'd0, 32'h8000);
      fire(2'd1, 3'd1, 1'b0, 32'hF000_0060, 1'b0, 2'd0, 32'h0);
      check_rd("R8 addr kept", 2'd3, 32'hE000_0050);
      check_rd("R8 no valid", 2'd0, 32'h0600);

      // R9 one-cycle request
      clear_all();
      fire(2'd2, 3'd0, 1'b0, 32'h0, 1'b0, 2'd0, 32'h0);
      check("R9 req high", {31'h0, req_usage}, 32'h1);
      @(negedge clk);
      check("R9 req dropped", {31'h0, req_usage}, 32'h0);

      // R11 vector table error and debug event
      clear_all();
      @(negedge clk);
      vtbl_err = 1'b1;
      @(negedge clk);
      idle();
      check("R11 vtbl req", {31'h0, req_hard}, 32'h1);
      check_rd("R11 vtbl bit", 2'd1, 32'h0000_0002);
      @(negedge clk);
      check("R11 req pulse", {31'h0, req_hard}, 32'h0);
      dbg_evt = 1'b1;
      @(negedge clk);
      idle();
      check("R11 dbg req", {31'h0, req_hard}, 32'h1);
      check_rd("R11 dbg bit", 2'd1, 32'h8000_0002);
      wr(2'd1, 32'hFFFF_FFFF);
      check_rd("R11 hard cleared", 2'd1, 32'h0);

      summary();
      $finish;
   end
endmodule